// File: doc/BRIEF.md
# Masked Port Mismatch Detector

The block compares several input ports against patterns that software stores, and it signals when any pin it has been told to watch no longer holds its expected level. Each port has two software-visible registers. The expected-level register holds the level each pin should have. The select register chooses which pins take part in the comparison. The pins are sampled directly from the pads, so the result does not depend on how the pins are routed to peripherals.

Each pin passes through a synchroniser before it is compared. The per-port results are combined into one registered level, `mismatch_o`. This level drives a wake request for power control. It also sets a sticky interrupt flag, which software reads and clears through the same register bus. The register bus has an address, a write strobe, write data, and read data that is returned in the same cycle.

Top module: `pin_pattern_watch`

## Requirements
- R1: After reset, every select register reads 0x00 and every expected-level register reads 0xFF. `mismatch_o`, `wake_o`, `irq_o` and the flag bit are all 0.
- R2: The expected-level register of port n is at address 0xF1+2n and the select register of port n is at 0xF2+2n. The flag register is at 0xF9. Read data for these addresses is returned combinationally from `reg_addr_i`. An unmapped address reads 0x00, and a write to an unmapped address changes no register.
- R3: A pin whose select bit is 0 never causes a mismatch, whatever its level and whatever its expected bit.
- R4: Port n mismatches when (pins AND select) differs from (expected AND select). An expected bit of 1 means the pin should be high, and 0 means it should be low.
- R5: `mismatch_o` is the OR of all ports. It stays at 1 while any one port mismatches.
- R6: A pin change reaches `mismatch_o` on the third rising clock edge after it is applied: two synchroniser stages, then the output register. A register write takes effect on `mismatch_o` at the clock edge after the write edge.
- R7: `mismatch_o` is a level. It stays at 1 for as long as the difference persists, and it returns to 0 once equality is restored.
- R8: The flag, read as bit 0 at 0xF9 and driven on `irq_o`, sets at the edge where `mismatch_o` rises. It stays set after `mismatch_o` falls.
- R9: A write to 0xF9 with bit 0 = 1 clears the flag. A write with bit 0 = 0 has no effect on the flag. If a clear and a rising `mismatch_o` occur at the same edge, the flag is left set.
- R10: `wake_o` follows `mismatch_o` whatever the state of the flag, including after the flag has been cleared while the mismatch persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NUM_PORTS*PORT_W | Raw pad levels; port n occupies bits n*PORT_W upward |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | PORT_W | Write data |
| reg_rdata_o | output | PORT_W | Read data for `reg_addr_i` |
| mismatch_o | output | 1 | Combined registered mismatch level |
| wake_o | output | 1 | Wake request, follows the mismatch level |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its defaults: four 8-bit ports, a two-stage synchroniser, the flag present, and a register base of 0xF1. This puts every port address, the flag address and the full three-edge pin latency within reach. The vector table places select and expected-level patterns on each port in turn, including cases where unselected pins differ. Directed tests then cover the edge-by-edge latency, two ports mismatching at once, the sticky flag, and a clear that collides with a new rising mismatch.

// File: rtl/ppw_pkg.sv
// Shared defaults and address helpers for the pin pattern watcher.
// Assumes each port uses two consecutive addresses (expected level, then
// select), and that the flag register follows the last port.
package ppw_pkg;
    localparam int unsigned PPW_PORTS_DEF  = 4;
    localparam int unsigned PPW_WIDTH_DEF  = 8;
    localparam int unsigned PPW_ADDR_W_DEF = 8;
    localparam int unsigned PPW_BASE_DEF   = 241; // 0xF1
    localparam int unsigned PPW_SYNC_DEF   = 2;
    localparam int unsigned PPW_CLR_BIT    = 0;

    // Address of the expected-level register for one port.
    function automatic int unsigned ppw_level_addr(int unsigned base, int unsigned port);
        return base + 2 * port;
    endfunction

    // Address of the select register for one port.
    function automatic int unsigned ppw_select_addr(int unsigned base, int unsigned port);
        return base + 2 * port + 1;
    endfunction

    // Address of the flag register, placed after the last port.
    function automatic int unsigned ppw_flag_addr(int unsigned base, int unsigned ports);
        return base + 2 * ports;
    endfunction
endpackage

// File: rtl/ppw_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pad levels.
// Assumes each bit is independent; no cross-bit coherence is required.
module ppw_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single stage: capture the pad levels.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q[0] <= d_i;
            end
        end else begin : g_chain
            // Shift the pad levels through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ppw_regs.sv
// Register file: an expected-level and a select register per port, and the
// decode of the flag register. Reads are combinational from the address.
// Assumes a single-cycle write strobe, and that unmapped addresses read zero.
module ppw_regs
    import ppw_pkg::*;
#(
    parameter int unsigned NUM_PORTS = PPW_PORTS_DEF,
    parameter int unsigned PORT_W    = PPW_WIDTH_DEF,
    parameter int unsigned ADDR_W    = PPW_ADDR_W_DEF,
    parameter int unsigned BASE      = PPW_BASE_DEF
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic                              we_i,
    input  logic [PORT_W-1:0]                 wdata_i,
    input  logic                              flag_i,
    output logic [PORT_W-1:0]                 rdata_o,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]  level_o,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]  select_o,
    output logic                              flag_clr_o
);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(ppw_flag_addr(BASE, NUM_PORTS));

    logic [NUM_PORTS-1:0][PORT_W-1:0] level_q;
    logic [NUM_PORTS-1:0][PORT_W-1:0] select_q;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            localparam logic [ADDR_W-1:0] LVL_ADDR = ADDR_W'(ppw_level_addr(BASE, p));
            localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(ppw_select_addr(BASE, p));

            // Expected-level register: resets to all pins expected high.
            always_ff @(posedge clk) begin
                if (!rst_n)                            level_q[p] <= '1;
                else if (we_i && addr_i == LVL_ADDR)   level_q[p] <= wdata_i;
            end

            // Select register: resets to all pins ignored.
            always_ff @(posedge clk) begin
                if (!rst_n)                            select_q[p] <= '0;
                else if (we_i && addr_i == SEL_ADDR)   select_q[p] <= wdata_i;
            end

            AST_SELECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && addr_i == SEL_ADDR) |=> (select_q[p] == $past(wdata_i))); // R2
            AST_LEVEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (we_i && addr_i == LVL_ADDR) |=> (level_q[p] == $past(wdata_i))); // R2
        end
    endgenerate

    // Read mux: return the register selected by the address, zero otherwise.
    always_comb begin
        rdata_o = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr_i == ADDR_W'(ppw_level_addr(BASE, p)))  rdata_o = level_q[p];
            if (addr_i == ADDR_W'(ppw_select_addr(BASE, p))) rdata_o = select_q[p];
        end
        if (addr_i == FLAG_ADDR) rdata_o = PORT_W'(flag_i);
    end

    assign level_o    = level_q;
    assign select_o   = select_q;
    assign flag_clr_o = we_i && (addr_i == FLAG_ADDR) && wdata_i[PPW_CLR_BIT];
endmodule

// File: rtl/ppw_compare.sv
// Per-port masked comparison combined into one level.
// Assumes the pins are already synchronised to clk. The result is combinational.
module ppw_compare #(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned PORT_W    = 8
) (
    input  logic [NUM_PORTS-1:0][PORT_W-1:0] pins_i,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0] level_i,
    input  logic [NUM_PORTS-1:0][PORT_W-1:0] select_i,
    output logic                             any_o
);
    logic [NUM_PORTS-1:0] port_diff;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cmp
            // A port differs when any selected pin departs from its expected level.
            assign port_diff[p] = (pins_i[p] & select_i[p]) != (level_i[p] & select_i[p]);
        end
    endgenerate

    assign any_o = |port_diff;
endmodule

// File: rtl/pin_pattern_watch.sv
// Top of the pin pattern watcher. Synchronises the pads, compares them with
// the stored patterns, registers the combined mismatch, and keeps a sticky
// flag. Assumes a synchronous active-low reset, and that the flag clear
// loses to a new rising mismatch at the same edge.
module pin_pattern_watch
    import ppw_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = PPW_PORTS_DEF,
    parameter int unsigned PORT_W      = PPW_WIDTH_DEF,
    parameter int unsigned ADDR_W      = PPW_ADDR_W_DEF,
    parameter int unsigned BASE        = PPW_BASE_DEF,
    parameter int unsigned SYNC_STAGES = PPW_SYNC_DEF,
    parameter bit          USE_FLAG    = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0]   pins_i,
    input  logic [ADDR_W-1:0]             reg_addr_i,
    input  logic                          reg_we_i,
    input  logic [PORT_W-1:0]             reg_wdata_i,
    output logic [PORT_W-1:0]             reg_rdata_o,
    output logic                          mismatch_o,
    output logic                          wake_o,
    output logic                          irq_o
);
    localparam int unsigned PIN_W = NUM_PORTS * PORT_W;

    logic [PIN_W-1:0]                 pins_sync;
    logic [NUM_PORTS-1:0][PORT_W-1:0] level_w;
    logic [NUM_PORTS-1:0][PORT_W-1:0] select_w;
    logic                             differ_now;
    logic                             mismatch_q;
    logic                             flag_q;
    logic                             flag_clr;
    logic                             rise_now;

    ppw_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (pins_sync)
    );

    ppw_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .we_i       (reg_we_i),
        .wdata_i    (reg_wdata_i),
        .flag_i     (flag_q),
        .rdata_o    (reg_rdata_o),
        .level_o    (level_w),
        .select_o   (select_w),
        .flag_clr_o (flag_clr)
    );

    ppw_compare #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_cmp (
        .pins_i   (pins_sync),
        .level_i  (level_w),
        .select_i (select_w),
        .any_o    (differ_now)
    );

    // Register the combined mismatch level.
    always_ff @(posedge clk) begin
        if (!rst_n) mismatch_q <= 1'b0;
        else        mismatch_q <= differ_now;
    end

    assign rise_now = differ_now && !mismatch_q;

    generate
        if (USE_FLAG) begin : g_flag
            // Sticky flag: set on a rising mismatch, which wins over a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)        flag_q <= 1'b0;
                else if (rise_now) flag_q <= 1'b1;
                else if (flag_clr) flag_q <= 1'b0;
            end

            AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mismatch_o) |-> flag_q); // R8
            AST_FLAG_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag_q) |-> $rose(mismatch_o)); // R8
            AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q && !flag_clr) |=> flag_q); // R8
            AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_clr && !rise_now) |=> !flag_q); // R9
        end else begin : g_noflag
            assign flag_q = 1'b0;
        end
    endgenerate

    AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(select_w == '0) |-> !mismatch_o); // R3

    assign mismatch_o = mismatch_q;
    assign wake_o     = mismatch_q;
    assign irq_o      = flag_q;
endmodule

// File: tb/pin_pattern_watch_test.sv
module pin_pattern_watch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        mismatch, wake, irq;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    pin_pattern_watch uut (
        .clk (clk), .rst_n (rst_n), .pins_i (pins),
        .reg_addr_i (addr), .reg_we_i (we), .reg_wdata_i (wdata),
        .reg_rdata_o (rdata), .mismatch_o (mismatch), .wake_o (wake), .irq_o (irq)
    );

    // {port[1:0], expected[7:0], select[7:0], pins[7:0], expected mismatch}
    localparam logic [26:0] VEC [8] = '{
        {2'd0, 8'hFF, 8'h00, 8'h00, 1'b0},  // R3 all ignored
        {2'd0, 8'hFF, 8'h01, 8'h00, 1'b1},  // R4 pin low, expected high
        {2'd1, 8'hA5, 8'hFF, 8'hA5, 1'b0},  // R4 exact match
        {2'd1, 8'hA5, 8'hFF, 8'hA4, 1'b1},  // R4 one pin off
        {2'd2, 8'h00, 8'hF0, 8'h0F, 1'b0},  // R3 differences only on unselected pins
        {2'd2, 8'h00, 8'hF0, 8'h10, 1'b1},  // R4 selected pin high, expected low
        {2'd3, 8'h80, 8'h80, 8'h80, 1'b0},  // R4 top pin as expected
        {2'd3, 8'h80, 8'h80, 8'h7F, 1'b1}   // R4 top pin low
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] r;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        chk("R1 mismatch", {7'd0, mismatch}, 8'h00);
        chk("R1 wake", {7'd0, wake}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        for (int p = 0; p < 4; p++) begin
            rd(8'(8'hF1 + 2*p), r); chk("R1 expected-level reset", r, 8'hFF);
            rd(8'(8'hF2 + 2*p), r); chk("R1 select reset", r, 8'h00);
        end
        rd(8'hF9, r); chk("R1 flag reset", r, 8'h00);

        // Vector table walk (R3, R4)
        for (int i = 0; i < 8; i++) begin
            int p;
            p = int'(VEC[i][26:25]);
            wr(8'(8'hF1 + 2*p), VEC[i][24:17]);
            wr(8'(8'hF2 + 2*p), VEC[i][16:9]);
            idle();
            pins[p*8 +: 8] = VEC[i][8:1];
            wait_n(3);
            chk($sformatf("R4 vector %0d", i), {7'd0, mismatch}, {7'd0, VEC[i][0]});
            wr(8'(8'hF2 + 2*p), 8'h00);
            wr(8'hF9, 8'h01);
            idle();
            wait_n(2);
        end
        pins = '0;
        chk("R3 all deselected", {7'd0, mismatch}, 8'h00);

        // R6 pin latency: port 0 pin 0 expected high
        wr(8'hF1, 8'hFF); wr(8'hF2, 8'h01); idle();
        pins[0] = 1'b1;
        wait_n(4);
        wr(8'hF9, 8'h01); idle();
        chk("R6 settled equal", {7'd0, mismatch}, 8'h00);
        pins[0] = 1'b0;
        wait_n(1); chk("R6 after edge 1", {7'd0, mismatch}, 8'h00);
        wait_n(1); chk("R6 after edge 2", {7'd0, mismatch}, 8'h00);
        wait_n(1); chk("R6 after edge 3", {7'd0, mismatch}, 8'h01);
        chk("R8 flag set on rise", {7'd0, irq}, 8'h01);
        rd(8'hF9, r); chk("R8 flag readback", r, 8'h01);
        wait_n(5);
        chk("R7 level persists", {7'd0, mismatch}, 8'h01);

        // R6 register latency: expect pin 0 low
        wr(8'hF1, 8'hFE); idle();
        chk("R6 write edge no change yet", {7'd0, mismatch}, 8'h01);
        wait_n(1);
        chk("R7 cleared after write", {7'd0, mismatch}, 8'h00);
        chk("R8 flag sticky", {7'd0, irq}, 8'h01);

        // R9 clear semantics
        wr(8'hF9, 8'h00); idle();
        chk("R9 bit0 zero keeps flag", {7'd0, irq}, 8'h01);
        wr(8'hF9, 8'h01); idle();
        chk("R9 clear", {7'd0, irq}, 8'h00);

        // R10 wake independent of flag
        wr(8'hF1, 8'hFF); idle(); wait_n(1);
        chk("R10 mismatch again", {7'd0, mismatch}, 8'h01);
        wr(8'hF9, 8'h01); idle();
        chk("R10 flag cleared", {7'd0, irq}, 8'h00);
        chk("R10 wake stays", {7'd0, wake}, 8'h01);

        // R9 collision: clear at the same edge as a new rise
        wr(8'hF1, 8'hFE); idle(); wait_n(2);
        wr(8'hF1, 8'hFF); idle(); wait_n(1);
        chk("R9 flag set before collision", {7'd0, irq}, 8'h01);
        wr(8'hF1, 8'hFE); idle(); wait_n(2);
        chk("R9 equality before collision", {7'd0, mismatch}, 8'h00);
        wr(8'hF1, 8'hFF);
        wr(8'hF9, 8'h01);
        idle();
        chk("R9 rise wins over clear", {7'd0, irq}, 8'h01);
        chk("R9 mismatch risen", {7'd0, mismatch}, 8'h01);

        // R5 OR across ports: port 0 still mismatching, add port 1
        wr(8'hF3, 8'h00); wr(8'hF4, 8'h01); idle();
        pins[8] = 1'b1;
        wait_n(3);
        pins[0] = 1'b1;
        wait_n(3);
        chk("R5 port 1 keeps output", {7'd0, mismatch}, 8'h01);
        pins[8] = 1'b0;
        wait_n(3);
        chk("R5 both ports equal", {7'd0, mismatch}, 8'h00);

        // R2 address map and unmapped access
        rd(8'hF4, r); chk("R2 port 1 select readback", r, 8'h01);
        rd(8'hF3, r); chk("R2 port 1 level readback", r, 8'h00);
        wr(8'h10, 8'hAA); idle();
        rd(8'h10, r); chk("R2 unmapped reads zero", r, 8'h00);
        rd(8'hF2, r); chk("R2 unmapped write ignored", r, 8'h01);
        rd(8'hF1, r); chk("R2 level unchanged", r, 8'hFF);
        rd(8'hFA, r); chk("R2 past flag reads zero", r, 8'h00);

        report();
    end
endmodule